// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-clock synchronous memory that keeps word storage in separate byte lanes. Every access has to be opened by an address load. Either of two active-low load strobes can start it: one for a processor and one for a controller. When both strobes are low on the same edge, the processor strobe has priority. A load captures the address and samples three chip selects of mixed polarity. If the selects do not all agree, the device goes idle.

While the device is selected, every rising edge is an access. The two low address bits come from a 2-bit burst counter, and an active-low step input advances that counter in linear order modulo 4. A global write writes the whole word. A byte write writes only the lanes that are picked. Any other access is a read.

Read data passes through two register stages, so it is on the output one clock after the edge that presented the address. The data bus is split into an input, an output and an output-enable flag, so the block has no tri-state logic. The output enable is combinational from the active-low enable input. It is held off in the first cycle after a device leaves the idle state, and during any write. A sleep input freezes all state, blocks every access and holds the output enable off.

Top module: `burst_sram`

## Requirements
- R1: While rst_ni is low, oe_o is 0 and rdata_o is all zeros.
- R2: A load edge is an edge with either load strobe low, subject to R3. On a load edge the address is captured, and the device becomes selected only if cs0_n_i=0, cs1_i=1 and cs2_n_i=0. Otherwise the device becomes idle. A load edge that leaves the device idle makes no access, and neither does an edge while the device is idle: nothing is written and nothing is driven.
- R3: cpu_ld_n_i is ignored on any edge where cs0_n_i is 1, and the burst then continues as if no load had occurred. ctl_ld_n_i is not gated by cs0_n_i, so a controller load with cs0_n_i=1 deselects the device.
- R4: A load puts addr_i[1:0] into the burst counter. On each later edge while the device is selected, the access address is the fixed upper address bits followed by the counter. The counter first adds 1 modulo 4 if step_n_i is 0, and keeps its value if step_n_i is 1.
- R5: An access with wr_all_n_i=0 writes all four lanes from wdata_i, whatever wr_byte_n_i and lane_sel_n_i are.
- R6: With wr_all_n_i=1 and wr_byte_n_i=0, lane i (data bits [8i+7:8i]) is written only if lane_sel_n_i[i]=0. An access that writes no lane is a read.
- R7: Data read at edge k is on rdata_o from edge k+1 until edge k+2, with oe_o=1 when oe_n_i=0. In the cycle after edge k+1, an access at edge k that was a write gives oe_o=0.
- R8: oe_o is 0 in any cycle where oe_n_i is 1.
- R9: In the cycle just after a selecting load made while the device was idle, oe_o is 0.
- R10: While sleep_i is 1, oe_o is 0. An edge that samples sleep_i=1 makes no access, writes nothing, and changes neither the burst counter nor the read pipeline, which resumes from the same point once sleep_i returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, captured on a load edge |
| cs0_n_i | input | 1 | Chip select, active low; also gates the processor strobe |
| cs1_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Chip select, active low |
| cpu_ld_n_i | input | 1 | Processor load strobe, active low, has priority |
| ctl_ld_n_i | input | 1 | Controller load strobe, active low |
| step_n_i | input | 1 | Burst step, active low |
| wr_all_n_i | input | 1 | Whole-word write, active low |
| wr_byte_n_i | input | 1 | Byte-write enable, active low |
| lane_sel_n_i | input | LANES | Per-lane write select, active low |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data |
| oe_o | output | 1 | High when rdata_o is to be driven onto the bus |

## Verification
A wrong burst counter or a lost upper-address capture shows up one cycle after the edge that uses it, as rdata_o holding the content of a different word. Wrap and hold bursts over known data expose it in the next read window. A lane-enable error stays hidden until the word is read back, so each byte write is followed directly by a read of the same word. Select, sleep and mask errors show at once in oe_o, in the same cycle or the one after the edge.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CPU  = 2'd1,
    LD_CTL  = 2'd2
  } ld_src_e;

  function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] c,
                                                    input logic step);
    return step ? c + BURST_W'(1) : c;
  endfunction
endpackage

// File: rtl/bsram_addr_seq.sv
`timescale 1ns/1ps
module bsram_addr_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               cs0_n_i,
  input  logic               cs1_i,
  input  logic               cs2_n_i,
  input  logic               cpu_ld_n_i,
  input  logic               ctl_ld_n_i,
  input  logic               step_n_i,
  output logic               acc_o,
  output logic [ADDR_W-1:0]  acc_addr_o,
  output logic               sel_q_o,
  output logic [BURST_W-1:0] cnt_o,
  output logic               load_o,
  output logic               first_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  ld_src_e            src;
  logic               cs_ok;
  logic               sel_q;
  logic [HI_W-1:0]    base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nx;

  // processor strobe only counts while cs0 is asserted; it wins over controller
  always_comb begin
    src = LD_NONE;
    if (!hold_i) begin
      if (!cpu_ld_n_i && !cs0_n_i) src = LD_CPU;
      else if (!ctl_ld_n_i)        src = LD_CTL;
    end
  end

  assign load_o  = (src != LD_NONE);
  assign cs_ok   = !cs0_n_i && cs1_i && !cs2_n_i;
  assign cnt_nx  = load_o ? addr_i[BURST_W-1:0] : burst_next(cnt_q, !step_n_i);
  assign acc_o   = load_o ? cs_ok : (sel_q && !hold_i);
  assign first_o = load_o && cs_ok && !sel_q;

  always_comb begin
    if (load_o) acc_addr_o = addr_i;
    else        acc_addr_o = {base_q, cnt_nx};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_o) begin
      sel_q  <= cs_ok;
      base_q <= addr_i[ADDR_W-1:BURST_W];
      cnt_q  <= addr_i[BURST_W-1:0];
    end else if (sel_q && !hold_i) begin
      cnt_q  <= cnt_nx;
    end
  end

  assign sel_q_o = sel_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/bsram_lane_mem.sv
`timescale 1ns/1ps
module bsram_lane_mem #(
  parameter int AW = 6,
  parameter int W  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/bsram_out_pipe.sv
`timescale 1ns/1ps
module bsram_out_pipe #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  logic              s1_v_q;
  logic              drv_q;
  logic [DATA_W-1:0] dout_q;

  // drv_q only rises one edge after a read, which also masks the first cycle out of idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q <= 1'b0;
      drv_q  <= 1'b0;
      dout_q <= '0;
    end else if (!hold_i) begin
      s1_v_q <= rd_vld_i;
      drv_q  <= s1_v_q;
      if (s1_v_q) dout_q <= rd_i;
    end
  end

  assign rdata_o = dout_q;
  assign oe_o    = drv_q && !oe_n_i && !sleep_i;
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cs0_n_i,
  input  logic                    cs1_i,
  input  logic                    cs2_n_i,
  input  logic                    cpu_ld_n_i,
  input  logic                    ctl_ld_n_i,
  input  logic                    step_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    wr_byte_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic               acc, acc_wr, acc_rd;
  logic [ADDR_W-1:0]  acc_addr;
  logic               sel_q, ld, first_ld;
  logic [BURST_W-1:0] cnt_q;
  logic [LANES-1:0]   lane_we;
  logic [DATA_W-1:0]  rd_raw;

  bsram_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (sleep_i),
    .addr_i     (addr_i),
    .cs0_n_i    (cs0_n_i),
    .cs1_i      (cs1_i),
    .cs2_n_i    (cs2_n_i),
    .cpu_ld_n_i (cpu_ld_n_i),
    .ctl_ld_n_i (ctl_ld_n_i),
    .step_n_i   (step_n_i),
    .acc_o      (acc),
    .acc_addr_o (acc_addr),
    .sel_q_o    (sel_q),
    .cnt_o      (cnt_q),
    .load_o     (ld),
    .first_o    (first_ld)
  );

  // a byte write with no lane picked falls back to a read
  assign acc_wr = !wr_all_n_i || (!wr_byte_n_i && !(&lane_sel_n_i));
  assign acc_rd = acc && !acc_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = acc && acc_wr && (!wr_all_n_i || !lane_sel_n_i[g]);

    bsram_lane_mem #(.AW(ADDR_W), .W(LANE_W)) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (lane_we[g]),
      .re_i    (acc_rd),
      .addr_i  (acc_addr),
      .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
      .rdata_o (rd_raw[g*LANE_W +: LANE_W])
    );
  end

  bsram_out_pipe #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (sleep_i),
    .rd_vld_i (acc_rd),
    .rd_i     (rd_raw),
    .oe_n_i   (oe_n_i),
    .sleep_i  (sleep_i),
    .rdata_o  (rdata_o),
    .oe_o     (oe_o)
  );
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_n_i,
  input logic              sleep_i,
  input logic              step_n_i,
  input logic              oe_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sel_q,
  input logic              load,
  input logic              first_ld,
  input logic [1:0]        cnt_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!oe_o && rdata_o == '0);
    end
  end

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !oe_o);

  assert_sleep_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !oe_o);

  assert_sleep_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(rdata_o) && $stable(cnt_q)));

  assert_burst_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && !load && !sleep_i && !step_n_i) |=> (cnt_q == $past(cnt_q) + 2'd1));

  assert_burst_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && !load && !sleep_i && step_n_i) |=> $stable(cnt_q));

  assert_first_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_ld |=> !oe_o);
endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .oe_n_i   (oe_n_i),
  .sleep_i  (sleep_i),
  .step_n_i (step_n_i),
  .oe_o     (oe_o),
  .rdata_o  (rdata_o),
  .sel_q    (sel_q),
  .load     (ld),
  .first_ld (first_ld),
  .cnt_q    (cnt_q)
);

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          cs0_n, cs1, cs2_n, cpu_n, ctl_n, step_n, wall_n, wbyte_n, oe_n, sleep;
  logic [3:0]    lsel_n;
  logic [DW-1:0] wdata, rdata;
  logic          oe;

  int n_chk = 0;
  int n_bad = 0;
  int edge_n = 0;

  typedef struct {
    int          due;
    bit          oe;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] ref_mem [64];

  always #10 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  burst_sram u_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cs0_n_i(cs0_n), .cs1_i(cs1), .cs2_n_i(cs2_n),
    .cpu_ld_n_i(cpu_n), .ctl_ld_n_i(ctl_n), .step_n_i(step_n), .wr_all_n_i(wall_n),
    .wr_byte_n_i(wbyte_n), .lane_sel_n_i(lsel_n), .oe_n_i(oe_n), .sleep_i(sleep),
    .wdata_i(wdata), .rdata_o(rdata), .oe_o(oe)
  );

  task automatic idle();
    addr = '0; cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0; cpu_n = 1'b1; ctl_n = 1'b1;
    step_n = 1'b1; wall_n = 1'b1; wbyte_n = 1'b1; lsel_n = 4'hF; oe_n = 1'b0;
    sleep = 1'b0; wdata = '0;
  endtask

  task automatic go();
    @(posedge clk);
    #2;
  endtask

  task automatic exp_rd(input int due, input logic [31:0] d, input string tag);
    exp_t it;
    it.due = due; it.oe = 1'b1; it.data = d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_off(input int due, input string tag);
    exp_t it;
    it.due = due; it.oe = 1'b0; it.data = '0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic desel();
    idle();
    ctl_n = 1'b0; cs1 = 1'b0;
    go();
    idle();
  endtask

  // monitor: compares every scoreboard item due in the current window
  always @(posedge clk) begin
    #15;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == edge_n) begin
        n_chk++;
        if (oe !== sb[i].oe || (sb[i].oe && rdata !== sb[i].data)) begin
          n_bad++;
          $display("FAIL %s: oe_o=%0b rdata_o=%h expected oe_o=%0b rdata_o=%h",
                   sb[i].tag, oe, rdata, sb[i].oe, sb[i].data);
        end
        sb.delete(i);
      end else if (sb[i].due < edge_n) begin
        n_chk++; n_bad++;
        $display("FAIL %s: item missed, actual edge %0d expected edge %0d", sb[i].tag, edge_n, sb[i].due);
        sb.delete(i);
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e;
    idle();
    go(); go();
    n_chk++;
    if (oe !== 1'b0 || rdata !== '0) begin
      n_bad++;
      $display("FAIL R1: oe_o=%0b rdata_o=%h expected 0 / 0", oe, rdata);
    end
    rst_n = 1'b1;
    go();

    // whole-word write burst 8..11 (R5, R4, R7)
    for (int k = 0; k < 4; k++) ref_mem[8 + k] = 32'h1000_0000 + 32'(k * 32'h0101_0101);
    e = edge_n + 1;
    ctl_n = 1'b0; addr = 6'd8; wall_n = 1'b0; wdata = ref_mem[8];
    exp_off(e + 1, "R7 write not driven");
    go();
    ctl_n = 1'b1; step_n = 1'b0;
    for (int k = 1; k < 4; k++) begin
      wdata = ref_mem[8 + k];
      go();
    end
    desel();

    // deselected load and idle edge with writes must not touch storage (R2)
    e = edge_n + 1;
    ctl_n = 1'b0; cs2_n = 1'b1; addr = 6'd8; wall_n = 1'b0; wdata = 32'hBAD0_BAD0;
    exp_off(e + 1, "R2 idle not driven");
    go();
    ctl_n = 1'b1; cs2_n = 1'b0;
    go();
    idle();

    // read burst from idle at 10: mask, latency, wrap, hold (R9, R7, R4, R2)
    e = edge_n + 1;
    cpu_n = 1'b0; addr = 6'd10;
    exp_off(e, "R9 first cycle masked");
    exp_rd(e + 1, ref_mem[10], "R7 read latency");
    go();
    cpu_n = 1'b1; step_n = 1'b0;
    exp_rd(e + 2, ref_mem[11], "R4 step");
    go();
    exp_rd(e + 3, ref_mem[8], "R4 wrap and R2 write ignored");
    go();
    exp_rd(e + 4, ref_mem[9], "R4 step after wrap");
    go();
    step_n = 1'b1;
    exp_rd(e + 5, ref_mem[9], "R4 hold");
    go();
    exp_off(e + 6, "R2 deselect");
    desel();

    // byte writes and whole-word override at 16 (R6, R5)
    ref_mem[16] = 32'h1122_3344;
    e = edge_n + 1;
    ctl_n = 1'b0; addr = 6'd16; wall_n = 1'b0; wdata = ref_mem[16];
    go();
    ctl_n = 1'b1; wall_n = 1'b1; wbyte_n = 1'b0; lsel_n = 4'b1010; wdata = 32'hAABB_CCDD;
    ref_mem[16] = 32'h11BB_33DD;
    go();
    lsel_n = 4'b1111;
    exp_rd(e + 3, ref_mem[16], "R6 lanes 0 and 2 only");
    go();
    wall_n = 1'b0; lsel_n = 4'b0111; wdata = 32'h5A5A_0F0F;
    ref_mem[16] = 32'h5A5A_0F0F;
    exp_off(e + 4, "R7 write not driven");
    go();
    wall_n = 1'b1; wbyte_n = 1'b1; lsel_n = 4'hF;
    exp_rd(e + 5, ref_mem[16], "R5 all lanes override");
    go();
    desel();

    // processor strobe gated by cs0, controller strobe not (R3), oe gate (R8)
    e = edge_n + 1;
    cpu_n = 1'b0; addr = 6'd10;
    exp_rd(e + 1, ref_mem[10], "R3 setup read");
    go();
    cpu_n = 1'b0; cs0_n = 1'b1; addr = 6'd32; step_n = 1'b0;
    exp_rd(e + 2, ref_mem[11], "R3 processor load ignored");
    go();
    cpu_n = 1'b1; cs0_n = 1'b0; step_n = 1'b1;
    go();
    ctl_n = 1'b0; cs0_n = 1'b1;
    exp_off(e + 3, "R8 oe_n high");
    exp_off(e + 4, "R3 controller deselect");
    go();
    idle();
    oe_n = 1'b1;
    go();
    oe_n = 1'b0;
    go();

    // sleep: outputs off, accesses blocked, state frozen (R10)
    ref_mem[24] = 32'hC0FF_EE01;
    e = edge_n + 1;
    ctl_n = 1'b0; addr = 6'd24; wall_n = 1'b0; wdata = ref_mem[24];
    go();
    ctl_n = 1'b1; wall_n = 1'b1;
    go();
    go();
    sleep = 1'b1; wall_n = 1'b0; step_n = 1'b0; wdata = 32'hDEAD_0000;
    exp_off(e + 2, "R10 oe off in sleep");
    exp_off(e + 3, "R10 oe off in sleep");
    go();
    go();
    idle();
    exp_rd(e + 4, ref_mem[24], "R10 pipeline resumes");
    exp_rd(e + 5, ref_mem[24], "R10 pipeline resumes");
    exp_rd(e + 6, ref_mem[24], "R10 write and step ignored");
    go();
    desel();
    go(); go(); go();

    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule